// File: doc/BRIEF.md
# Bus Fabric Control and Event Counter Registers

This block sits on an APB bus and gives software control over the bus fabric around it. It holds one priority bit for each bus master and drives those bits to the fabric arbiters. It also reports, through a read-only status bit, whether every arbiter has taken up the most recent priority setting.

The block also has four independent event counters. Each counter has its own selector, which picks one pulse from a vector of twenty arbiter events. The events cover, for each of ten downstream ports, the accesses that met contention and the total accesses. A counter stops at its all-ones value instead of wrapping, and any write to its address clears it. After reset a selector holds a code that matches no event, so a counter stays idle until software chooses an event for it.

The APB slave has no wait states. Reads are combinational from the register state, and writes take effect at the clock edge that ends the access phase.

Top module: `fabric_ctl_regs`

## Requirements
- R1: After a synchronous reset the master priority bits read 0, the acknowledge bit reads 0, every counter reads 0 and every selector reads 0x1F.
- R2: The word at 0x00 stores one priority bit per master, taken from write-data bits 0, 4, 8 and 12 for masters 0 to 3. A 1 means high priority. All other bits read 0. `master_prio` drives the stored bits.
- R3: The acknowledge bit at 0x04 (bit 0) is read-only. After each clock edge it equals the AND of `arb_uptodate` sampled at that edge. The exception is an edge that commits a write to 0x00: after that edge the bit reads 0.
- R4: The selector of counter i sits at 0x0C+8*i. It stores write-data bits 4:0, and bits 31:5 read 0.
- R5: Selector code c counts event bit c of `fabric_events`. Bit 2k is the contested-access pulse of port k and bit 2k+1 is its all-access pulse. Ports are numbered apb=0, fastperi=1, sram5..sram0=2..7, xip_main=8 and rom=9.
- R6: Selector codes 0x14 to 0x1F count nothing.
- R7: Counter i, at 0x08+8*i, rises by one at each clock edge where its selected event is high. It is CNT_W bits wide (24 by default), and the bits above it read 0.
- R8: A counter at all ones (0xFFFFFF by default) holds that value while further events arrive.
- R9: A write of any value to a counter's address sets it to 0. When a clearing write and an event fall on the same edge, the clear wins.
- R10: A write to one counter or selector leaves the other counters, the other selectors and the priority bits unchanged.
- R11: `pready` is always 1 and `pslverr` is always 0. Reads of words at 0x28 and above return 0, and writes to those words change no state. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W (8) | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid while selected for a read |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| arb_uptodate | input | N_ARB (10) | One bit per arbiter: the current priority is registered |
| fabric_events | input | 20 | Event pulses, two per downstream port |
| master_prio | output | 4 | Priority bit per master, to the arbiters |

## Verification
A counter stuck, wrapping or wrongly cleared appears at its read port on the next read. The reference model checks every read in every cycle, so the error shows within one read after the edge that caused it. A wrong selector decode makes a counter that should stay still move, or one that should move stay still. Two counters are driven with all events high to separate these cases. A stale acknowledge bit is caught by a read issued in the setup phase directly after a priority write, which is the one cycle in which the bit must read 0.

// File: rtl/fabric_ctl_pkg.sv
package fabric_ctl_pkg;

    localparam int NUM_MASTER  = 4;
    localparam int PRIO_STRIDE = 4;
    localparam int NUM_PORT    = 10;
    localparam int NUM_EVT     = 2 * NUM_PORT;
    localparam int NUM_CTR     = 4;
    localparam int SEL_W       = 5;
    localparam logic [SEL_W-1:0] SEL_RESET = '1;
    localparam int DATA_W      = 32;

    localparam int W_PRIO      = 0;
    localparam int W_ACK       = 1;
    localparam int W_CTR_BASE  = 2;
    localparam int NUM_WORDS   = W_CTR_BASE + 2 * NUM_CTR;

    typedef struct packed {
        logic rd;
        logic wr;
    } apb_acc_t;

    function automatic logic evt_pick(input logic [SEL_W-1:0] code,
                                      input logic [NUM_EVT-1:0] evts);
        logic hit;
        hit = 1'b0;
        for (int e = 0; e < NUM_EVT; e++) begin
            if (code == SEL_W'(e)) hit = evts[e];
        end
        return hit;
    endfunction

endpackage

// File: rtl/fabric_prio_reg.sv
module fabric_prio_reg
    import fabric_ctl_pkg::*;
#(
    parameter int N_ARB = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [NUM_MASTER-1:0] wbits,
    input  logic [N_ARB-1:0]      uptodate,
    output logic [NUM_MASTER-1:0] prio,
    output logic                  ack
);

    logic [NUM_MASTER-1:0] prio_q;
    logic                  ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
            ack_q  <= 1'b0;
        end else if (we) begin
            prio_q <= wbits;
            ack_q  <= 1'b0;
        end else begin
            ack_q  <= &uptodate;
        end
    end

    assign prio = prio_q;
    assign ack  = ack_q;

    p_ack_drop_r3: assert property (@(posedge clk) disable iff (rst)
        we |=> !ack_q);
    p_ack_all_r3: assert property (@(posedge clk) disable iff (rst)
        ack_q |-> $past(&uptodate));
    p_prio_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(prio_q));

endmodule

// File: rtl/fabric_perf_ctr.sv
module fabric_perf_ctr
    import fabric_ctl_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               sel_we,
    input  logic [SEL_W-1:0]   sel_wdata,
    input  logic [NUM_EVT-1:0] evts,
    output logic [CNT_W-1:0]   count,
    output logic [SEL_W-1:0]   sel
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic             hit;

    assign hit = evt_pick(sel_q, evts);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (hit && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= SEL_RESET;
        end else if (sel_we) begin
            sel_q <= sel_wdata;
        end
    end

    assign count = cnt_q;
    assign sel   = sel_q;

    p_sat_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == '0);
    p_undef_code_r6: assert property (@(posedge clk) disable iff (rst)
        (int'(sel_q) >= NUM_EVT && !clr) |=> $stable(cnt_q));
    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        (hit && !clr && cnt_q != CNT_MAX) |=> (cnt_q - $past(cnt_q)) == CNT_W'(1));
    p_sel_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !sel_we |=> $stable(sel_q));

endmodule

// File: rtl/fabric_ctl_regs.sv
module fabric_ctl_regs
    import fabric_ctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 24,
    parameter int N_ARB  = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  psel,
    input  logic                  penable,
    input  logic                  pwrite,
    input  logic [ADDR_W-1:0]     paddr,
    input  logic [DATA_W-1:0]     pwdata,
    output logic [DATA_W-1:0]     prdata,
    output logic                  pready,
    output logic                  pslverr,
    input  logic [N_ARB-1:0]      arb_uptodate,
    input  logic [NUM_EVT-1:0]    fabric_events,
    output logic [NUM_MASTER-1:0] master_prio
);

    localparam int WORD_W = ADDR_W - 2;

    apb_acc_t              acc;
    logic [WORD_W-1:0]     word;
    logic [NUM_MASTER-1:0] prio_wbits;
    logic                  prio_ack;
    logic [CNT_W-1:0]      cnt_a [NUM_CTR];
    logic [SEL_W-1:0]      sel_a [NUM_CTR];
    logic                  unused_bits;

    assign word        = paddr[ADDR_W-1:2];
    assign acc.rd      = psel & ~pwrite;
    assign acc.wr      = psel & penable & pwrite;
    assign unused_bits = ^{paddr[1:0], pwdata};

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    for (genvar m = 0; m < NUM_MASTER; m++) begin : g_pbits
        assign prio_wbits[m] = pwdata[m*PRIO_STRIDE];
    end

    fabric_prio_reg #(.N_ARB(N_ARB)) u_prio (
        .clk      (clk),
        .rst      (rst),
        .we       (acc.wr && word == WORD_W'(W_PRIO)),
        .wbits    (prio_wbits),
        .uptodate (arb_uptodate),
        .prio     (master_prio),
        .ack      (prio_ack)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        fabric_perf_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk       (clk),
            .rst       (rst),
            .clr       (acc.wr && word == WORD_W'(W_CTR_BASE + 2*i)),
            .sel_we    (acc.wr && word == WORD_W'(W_CTR_BASE + 2*i + 1)),
            .sel_wdata (pwdata[SEL_W-1:0]),
            .evts      (fabric_events),
            .count     (cnt_a[i]),
            .sel       (sel_a[i])
        );
    end

    always_comb begin
        prdata = '0;
        if (acc.rd) begin
            if (word == WORD_W'(W_PRIO)) begin
                for (int m = 0; m < NUM_MASTER; m++) prdata[m*PRIO_STRIDE] = master_prio[m];
            end
            if (word == WORD_W'(W_ACK)) prdata[0] = prio_ack;
            for (int i = 0; i < NUM_CTR; i++) begin
                if (word == WORD_W'(W_CTR_BASE + 2*i))     prdata[CNT_W-1:0] = cnt_a[i];
                if (word == WORD_W'(W_CTR_BASE + 2*i + 1)) prdata[SEL_W-1:0] = sel_a[i];
            end
        end
    end

    p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && int'(word) >= NUM_WORDS) |-> prdata == '0);
    p_prio_ack_rd_r3: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && word == WORD_W'(W_ACK)) |-> prdata[DATA_W-1:1] == '0);

endmodule

// File: tb/fabric_ctl_regs_test.sv
module fabric_ctl_regs_test;
    localparam int CW = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [9:0]  upd = '0;
    logic [19:0] ev = '0;
    logic [3:0]  mprio;

    int total = 0, bad = 0;
    bit done = 0;

    fabric_ctl_regs #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .arb_uptodate(upd), .fabric_events(ev), .master_prio(mprio)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    int         m_cnt [4];
    logic [4:0] m_sel [4];
    logic [3:0] m_prio;
    bit         m_ack;

    always @(posedge clk) begin
        bit wr;
        int w;
        wr = psel && penable && pwrite;
        w  = int'(paddr[7:2]);
        if (rst) begin
            for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_sel[i] = 5'h1F; end
            m_prio = 0; m_ack = 0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (wr && w == 2 + 2*i) m_cnt[i] = 0;
                else if (m_sel[i] < 20 && ev[m_sel[i]] && m_cnt[i] < CMAX) m_cnt[i]++;
                if (wr && w == 3 + 2*i) m_sel[i] = pwdata[4:0];
            end
            if (wr && w == 0) begin
                m_prio = {pwdata[12], pwdata[8], pwdata[4], pwdata[0]};
                m_ack = 0;
            end else m_ack = &upd;
        end
    end

    function automatic logic [31:0] mread(input logic [7:0] a);
        int w;
        w = int'(a[7:2]);
        if (w == 0) return {19'd0, m_prio[3], 3'd0, m_prio[2], 3'd0, m_prio[1], 3'd0, m_prio[0]};
        if (w == 1) return {31'd0, m_ack};
        for (int i = 0; i < 4; i++) begin
            if (w == 2 + 2*i) return 32'(m_cnt[i]);
            if (w == 3 + 2*i) return {27'd0, m_sel[i]};
        end
        return 32'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            chk("R2 master_prio", 32'(mprio), 32'(m_prio));
            chk("R11 ready/err", {30'd0, pready, pslverr}, 32'h2);
            if (psel && !pwrite) chk("model read", prdata, mread(paddr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    // samples in the setup phase, then completes the access
    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        #1 chk(req, prdata, exp);
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic pulse(input logic [19:0] v, input int n);
        ev = v;
        repeat (n) @(negedge clk);
        ev = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1; total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 prio out", 32'(mprio), 32'h0);
        rd(8'h00, 32'h0, "R1 prio");
        rd(8'h04, 32'h0, "R1 ack");
        for (int i = 0; i < 4; i++) begin
            rd(8'(8 + 8*i), 32'h0, "R1 counter");
            rd(8'(12 + 8*i), 32'h1F, "R1 selector");
        end
        // R2 priority bits only
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0000_1111, "R2 prio readback");
        chk("R2 prio out", 32'(mprio), 32'hF);
        // R3 acknowledge
        upd = '1;
        repeat (2) @(negedge clk);
        rd(8'h04, 32'h1, "R3 ack all up");
        wr(8'h00, 32'h0000_0010);
        rd(8'h04, 32'h0, "R3 ack low after prio write");
        rd(8'h04, 32'h1, "R3 ack back");
        chk("R2 prio out 2", 32'(mprio), 32'h2);
        upd = 10'h3FE;
        @(negedge clk);
        rd(8'h04, 32'h0, "R3 one arbiter stale");
        // R4 selector width
        wr(8'h0C, 32'hFFFF_FFE3);
        rd(8'h0C, 32'h03, "R4 selector bits");
        // R5 code mapping: 0x05 = sram5 all accesses
        wr(8'h0C, 32'h05);
        pulse(20'h00010, 4);
        pulse(20'h00020, 7);
        rd(8'h08, 32'd7, "R5 code 5 counts bit 5 only");
        // R5/R6/R7 several counters, all events high
        wr(8'h14, 32'h13);
        wr(8'h1C, 32'h00);
        pulse('1, 10);
        rd(8'h08, 32'd17, "R7 counter0");
        rd(8'h10, 32'd10, "R5 rom code 0x13");
        rd(8'h18, 32'd10, "R5 apb contested code 0");
        rd(8'h20, 32'd0, "R6 reset code 0x1F");
        wr(8'h24, 32'h14);
        pulse('1, 5);
        rd(8'h20, 32'd0, "R6 code 0x14");
        rd(8'h10, 32'd15, "R7 counter1");
        // R8 saturation
        wr(8'h1C, 32'h01);
        pulse('1, 300);
        rd(8'h18, 32'(CMAX), "R8 saturated");
        rd(8'h08, 32'(CMAX), "R8 saturated c0");
        // R9/R10 clear by any value
        wr(8'h18, 32'hDEAD_BEEF);
        rd(8'h18, 32'd0, "R9 clear");
        rd(8'h10, 32'(CMAX), "R10 other counter kept");
        rd(8'h1C, 32'h01, "R10 selector kept");
        // R9 clear beats same-cycle event
        ev = '1;
        wr(8'h10, 32'h0);
        rd(8'h10, 32'd0, "R9 clear wins");
        ev = '0;
        // R11 unmapped words
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h3D, 32'hFFFF_FFFF);
        rd(8'h28, 32'd0, "R11 unmapped read");
        rd(8'h3C, 32'd0, "R11 unmapped read 2");
        rd(8'h00, 32'h0000_0010, "R11 prio untouched");
        rd(8'h0E, 32'h05, "R11 low address bits ignored");
        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule